// File: doc/BRIEF.md
# Dual Machine-Cycle Timer/Counter

This block holds two 16-bit timer/counters, unit 0 and unit 1. Each unit is a low byte and a high byte that can be arranged in four ways. A mode byte picks, for each unit, the arrangement, a gating option and whether the unit counts machine-cycle ticks or falling edges on an external count pin. A control byte holds the two run bits and the two sticky overflow flags. The flags leave the block on `tmr_ovf` as interrupt requests.

The processor reaches all state through a byte-wide register port. It has a write address and a separate, purely combinational read address. The port has no back-pressure. A write presented with `reg_we` high takes effect at the next clock edge, and a read returns the current register value in the same cycle. External count and gate pins are asynchronous. Each one passes through a synchronizer before it is used.

Top module: `dual_tmr_top`

## Requirements
- R1: Register addresses are: 0 mode, 1 control, 2 unit-0 low, 3 unit-0 high, 4 unit-1 low, 5 unit-1 high. Any other address reads 0. Mode bits: [1:0] unit-0 mode, [2] unit-0 counter-select, [3] unit-0 gate, [5:4] unit-1 mode, [6] unit-1 counter-select, [7] unit-1 gate. Control bits: [0] run0, [1] run1, [2] flag0, [3] flag1, and the upper bits read 0. After reset every register reads 0 and both `tmr_ovf` bits are 0.
- R2: A unit advances only when its run bit is 1 and either its gate bit is 0 or its gate pin, after two synchronizing flops, is high.
- R3: With counter-select 0, an enabled unit advances once per clock in which `tick` is high. With counter-select 1, it advances once per falling edge of its count pin. The edge is counted on the third rising clock edge after the pin falls.
- R4: Mode 00 counts the 13-bit value {high byte, low[4:0]}. Bits low[7:5] keep their written value. Rolling over from all ones sets the unit's flag.
- R5: Mode 01 counts the 16-bit value {high, low}. Rolling over from 0xFFFF sets the unit's flag.
- R6: Mode 10 counts the low byte only. When it counts past 0xFF, the low byte loads the high byte and the flag is set. The high byte does not change.
- R7: A flag is set one clock after its overflow. It stays set until a control write with that bit 0 or a `flag_clr` pulse. If a set and a clear fall in the same cycle, the set wins.
- R8: Writing run bits, including setting them, leaves the count bytes unchanged.
- R9: Unit 1 in mode 11 holds both of its bytes.
- R10: Unit 0 in mode 11 splits. The low byte counts with unit-0 run, gate and source and sets flag0 on rollover. The high byte counts `tick` whenever run1 is 1 and sets flag1 on rollover. While this holds, unit-1 rollovers do not set flag1.
- R11: A write to a count byte replaces that byte at the next edge. The other byte of the unit still takes its counted value in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Machine-cycle enable for timer counting |
| cnt_pin | input | 2 | External count pins, bit i for unit i (asynchronous) |
| gate_pin | input | 2 | External gate pins, bit i for unit i (asynchronous) |
| flag_clr | input | 2 | One-cycle clear of flag i |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write address |
| reg_wdata | input | 8 | Register write data |
| reg_raddr | input | 3 | Register read address |
| reg_rdata | output | 8 | Register read data (combinational) |
| tmr_ovf | output | 2 | Overflow flags / interrupt requests |

## Verification
A wrong count or wrong mode decode appears on the read port in the next cycle, because every byte is compared against an independent model on every clock. A wrong rollover or wrong reload also moves a flag, so it shows on `tmr_ovf` one cycle after the offending edge. A misrouted split-mode overflow shows as a flag1 change with no unit-1 rollover. A synchronizer with the wrong depth is caught within one edge, since every count and gate decision shifts by a cycle against the model.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int BYTE_W  = 8;
  localparam int PRESC_W = 5;
  localparam int ADDR_W  = 3;
  localparam int N_TMR   = 2;

  typedef enum logic [1:0] {
    MD_PRESC13 = 2'b00,
    MD_CASC16  = 2'b01,
    MD_RELOAD8 = 2'b10,
    MD_SPLIT   = 2'b11
  } tmr_mode_e;

  localparam int A_MODE = 0;
  localparam int A_CTRL = 1;
  localparam int A_LO0  = 2;
  localparam int A_HI0  = 3;
  localparam int A_LO1  = 4;
  localparam int A_HI1  = 5;
endpackage

// File: rtl/dtmr_sync.sv
module dtmr_sync #(
  parameter int STAGES = 2,
  parameter bit EDGE   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic sig
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], din};
  end

  if (EDGE) begin : g_fall
    logic last;
    always_ff @(posedge clk) begin
      if (!rst_n) last <= 1'b0;
      else        last <= chain[STAGES-1];
    end
    assign sig = last & ~chain[STAGES-1];

    // R3: a single falling edge yields a single count pulse
    p_fall_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sig |=> !sig);
  end else begin : g_level
    assign sig = chain[STAGES-1];
  end
endmodule

// File: rtl/dtmr_core.sv
module dtmr_core
  import dtmr_pkg::*;
#(
  parameter int W     = 8,
  parameter int PW    = 5,
  parameter bit SPLIT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  tmr_mode_e    mode,
  input  logic         cnt_en,
  input  logic         hi_en,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] lo_q,
  output logic [W-1:0] hi_q,
  output logic         ovf_main,
  output logic         ovf_hi
);
  localparam int PRE_W = W + PW;
  localparam int CAS_W = 2 * W;

  logic [PRE_W-1:0] pre_v, pre_inc;
  logic [CAS_W-1:0] cas_v, cas_inc;
  logic [W-1:0]     lo_nx, hi_nx, sp_lo, sp_hi;
  logic             sp_ovf_lo, sp_ovf_hi;

  assign pre_v   = {hi_q, lo_q[PW-1:0]};
  assign pre_inc = pre_v + PRE_W'(1);
  assign cas_v   = {hi_q, lo_q};
  assign cas_inc = cas_v + CAS_W'(1);

  if (SPLIT) begin : g_split
    assign sp_lo     = cnt_en ? lo_q + W'(1) : lo_q;
    assign sp_hi     = hi_en  ? hi_q + W'(1) : hi_q;
    assign sp_ovf_lo = cnt_en & (&lo_q);
    assign sp_ovf_hi = hi_en  & (&hi_q);
  end else begin : g_hold
    assign sp_lo     = lo_q;
    assign sp_hi     = hi_q;
    assign sp_ovf_lo = 1'b0;
    assign sp_ovf_hi = 1'b0;

    // R10: only the splittable unit may receive a high-byte enable
    p_no_hi_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !hi_en);
    // R9: a stopped unit keeps both bytes
    p_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_SPLIT && !wr_lo && !wr_hi) |=> (lo_q == $past(lo_q) && hi_q == $past(hi_q)));
  end

  always_comb begin
    lo_nx    = lo_q;
    hi_nx    = hi_q;
    ovf_main = 1'b0;
    unique case (mode)
      MD_PRESC13: if (cnt_en) begin
        lo_nx    = {lo_q[W-1:PW], pre_inc[PW-1:0]};
        hi_nx    = pre_inc[PRE_W-1:PW];
        ovf_main = &pre_v;
      end
      MD_CASC16: if (cnt_en) begin
        {hi_nx, lo_nx} = cas_inc;
        ovf_main       = &cas_v;
      end
      MD_RELOAD8: if (cnt_en) begin
        if (&lo_q) begin
          lo_nx    = hi_q;
          ovf_main = 1'b1;
        end else begin
          lo_nx = lo_q + W'(1);
        end
      end
      default: begin
        lo_nx    = sp_lo;
        hi_nx    = sp_hi;
        ovf_main = sp_ovf_lo;
      end
    endcase
  end

  assign ovf_hi = (mode == MD_SPLIT) & sp_ovf_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= wr_lo ? wdata : lo_nx;
      hi_q <= wr_hi ? wdata : hi_nx;
    end
  end

  // R2: with no enable and no write, nothing moves
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !hi_en && !wr_lo && !wr_hi) |=> ($stable(lo_q) && $stable(hi_q)));
  // R4: prescaler mode never touches the upper low-byte bits
  p_presc_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_PRESC13 && !wr_lo) |=> (lo_q[W-1:PW] == $past(lo_q[W-1:PW])));
  // R6: reload copies the high byte
  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_RELOAD8 && cnt_en && (&lo_q) && !wr_lo) |=> (lo_q == $past(hi_q)));
  // R6: reload mode leaves the high byte alone
  p_reload_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_RELOAD8 && !wr_hi) |=> (hi_q == $past(hi_q)));
  // R11: a byte write lands at the next edge
  p_wr_lo_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (lo_q == $past(wdata)));
endmodule

// File: rtl/dual_tmr_top.sv
module dual_tmr_top
  import dtmr_pkg::*;
#(
  parameter int DATA_W      = BYTE_W,
  parameter int PRE_W       = PRESC_W,
  parameter int SYNC_STAGES = 2,
  parameter int AW          = ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [1:0]        cnt_pin,
  input  logic [1:0]        gate_pin,
  input  logic [1:0]        flag_clr,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_waddr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [AW-1:0]     reg_raddr,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [1:0]        tmr_ovf
);
  localparam int NT       = N_TMR;
  localparam int FIELD_W  = DATA_W / NT;

  logic [DATA_W-1:0]         mode_q;
  logic [NT-1:0]             run_q, flag_q, flag_set, flag_base;
  logic [NT-1:0]             cnt_fall, gate_lvl, cnt_en, hi_en, wr_lo, wr_hi;
  logic [NT-1:0]             ovf_main, ovf_hi;
  logic [NT-1:0][DATA_W-1:0] lo_q, hi_q;
  logic                      mode_wr, ctrl_wr, split0;

  assign mode_wr = reg_we && (reg_waddr == AW'(A_MODE));
  assign ctrl_wr = reg_we && (reg_waddr == AW'(A_CTRL));
  assign split0  = (mode_q[1:0] == MD_SPLIT);

  assign hi_en[0] = tick & run_q[1];
  assign hi_en[1] = 1'b0;

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    tmr_mode_e md;
    logic      ct_sel, gate_sel, gate_ok;

    assign md       = tmr_mode_e'(mode_q[FIELD_W*i+1 -: 2]);
    assign ct_sel   = mode_q[FIELD_W*i+2];
    assign gate_sel = mode_q[FIELD_W*i+3];
    assign gate_ok  = run_q[i] & (~gate_sel | gate_lvl[i]);
    assign cnt_en[i] = gate_ok & (ct_sel ? cnt_fall[i] : tick);
    assign wr_lo[i] = reg_we && (reg_waddr == AW'(A_LO0 + 2*i));
    assign wr_hi[i] = reg_we && (reg_waddr == AW'(A_HI0 + 2*i));

    dtmr_sync #(.STAGES(SYNC_STAGES), .EDGE(1'b1)) u_cnt_sync (
      .clk(clk), .rst_n(rst_n), .din(cnt_pin[i]), .sig(cnt_fall[i]));
    dtmr_sync #(.STAGES(SYNC_STAGES), .EDGE(1'b0)) u_gate_sync (
      .clk(clk), .rst_n(rst_n), .din(gate_pin[i]), .sig(gate_lvl[i]));

    dtmr_core #(.W(DATA_W), .PW(PRE_W), .SPLIT(i == 0)) u_core (
      .clk(clk), .rst_n(rst_n), .mode(md), .cnt_en(cnt_en[i]), .hi_en(hi_en[i]),
      .wr_lo(wr_lo[i]), .wr_hi(wr_hi[i]), .wdata(reg_wdata),
      .lo_q(lo_q[i]), .hi_q(hi_q[i]), .ovf_main(ovf_main[i]), .ovf_hi(ovf_hi[i]));
  end

  assign flag_set[0] = ovf_main[0];
  assign flag_set[1] = split0 ? ovf_hi[0] : (ovf_main[1] | ovf_hi[1]);
  assign flag_base   = ctrl_wr ? reg_wdata[NT+1:NT] : flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      run_q  <= '0;
      flag_q <= '0;
    end else begin
      if (mode_wr) mode_q <= reg_wdata;
      if (ctrl_wr) run_q  <= reg_wdata[NT-1:0];
      flag_q <= (flag_base & ~flag_clr) | flag_set;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (int'(reg_raddr))
      A_MODE:  reg_rdata = mode_q;
      A_CTRL:  reg_rdata = DATA_W'({flag_q, run_q});
      A_LO0:   reg_rdata = lo_q[0];
      A_HI0:   reg_rdata = hi_q[0];
      A_LO1:   reg_rdata = lo_q[1];
      A_HI1:   reg_rdata = hi_q[1];
      default: reg_rdata = '0;
    endcase
  end

  assign tmr_ovf = flag_q;

  // R7: an overflow raises the flag on the next edge
  p_flag_set0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_main[0] |=> tmr_ovf[0]);
  // R7: without a clear the flag stays set
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_ovf[1] && !flag_clr[1] && !ctrl_wr) |=> tmr_ovf[1]);
  // R10: split high-byte rollover is routed to flag1
  p_split_route_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (split0 && ovf_hi[0]) |=> tmr_ovf[1]);
  // R8: a control write does not disturb an idle count
  p_run_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !cnt_en[1] && !wr_lo[1] && !wr_hi[1]) |=> $stable(lo_q[1]));
endmodule

// File: tb/dual_tmr_top_tb_top.sv
`timescale 1ns/10ps
module dual_tmr_top_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, reg_we = 1'b0;
  logic [1:0] cnt_pin = 2'b11, gate_pin = 2'b00, flag_clr = 2'b00, tmr_ovf;
  logic [2:0] reg_waddr = '0, reg_raddr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;

  int checks = 0, errors = 0;
  bit done = 0, chk_on = 0;
  string cur_req = "R1";

  int m_mode, m_run[2], m_flag[2], m_lo[2], m_hi[2];
  int c1[2], c2[2], cp[2], g1[2], g2[2];

  always #2 clk = ~clk;

  dual_tmr_top dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
    .flag_clr(flag_clr), .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .tmr_ovf(tmr_ovf));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_rd(input int a);
    case (a)
      0: return m_mode;
      1: return m_run[0] | (m_run[1] << 1) | (m_flag[0] << 2) | (m_flag[1] << 3);
      2: return m_lo[0];
      3: return m_hi[0];
      4: return m_lo[1];
      5: return m_hi[1];
      default: return 0;
    endcase
  endfunction

  // behavioural reference of one unit for one clock
  task automatic step_unit(input int idx, input int md, input bit en, input bit hen,
                           inout int lo, inout int hi, output bit ovm, output bit ovh);
    int v;
    ovm = 0; ovh = 0;
    case (md)
      0: if (en) begin
        v = hi * 32 + (lo % 32);
        ovm = (v == 8191);
        v = (v + 1) % 8192;
        hi = v / 32;
        lo = (lo / 32) * 32 + (v % 32);
      end
      1: if (en) begin
        v = hi * 256 + lo;
        ovm = (v == 65535);
        v = (v + 1) % 65536;
        hi = v / 256;
        lo = v % 256;
      end
      2: if (en) begin
        if (lo == 255) begin lo = hi; ovm = 1; end
        else lo = lo + 1;
      end
      default: if (idx == 0) begin
        if (en)  begin ovm = (lo == 255); lo = (lo + 1) % 256; end
        if (hen) begin ovh = (hi == 255); hi = (hi + 1) % 256; end
      end
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0;
      for (int i = 0; i < 2; i++) begin
        m_run[i] = 0; m_flag[i] = 0; m_lo[i] = 0; m_hi[i] = 0;
        c1[i] = 0; c2[i] = 0; cp[i] = 0; g1[i] = 0; g2[i] = 0;
      end
    end else begin
      bit en[2];
      bit ovm[2], ovh[2], set[2];
      int md, base;
      for (int i = 0; i < 2; i++) begin
        md = (m_mode >> (4 * i)) & 15;
        en[i] = m_run[i] && (((md >> 3) & 1) == 0 || g2[i] == 1) &&
                (((md >> 2) & 1) ? (cp[i] == 1 && c2[i] == 0) : (tick == 1));
      end
      step_unit(0, m_mode & 3, en[0], tick && m_run[1] == 1, m_lo[0], m_hi[0], ovm[0], ovh[0]);
      step_unit(1, (m_mode >> 4) & 3, en[1], 1'b0, m_lo[1], m_hi[1], ovm[1], ovh[1]);
      set[0] = ovm[0];
      set[1] = ((m_mode & 3) == 3) ? ovh[0] : ovm[1];
      base = 0;
      if (reg_we) begin
        case (int'(reg_waddr))
          0: m_mode = reg_wdata;
          1: begin m_run[0] = reg_wdata[0]; m_run[1] = reg_wdata[1]; end
          2: m_lo[0] = reg_wdata;
          3: m_hi[0] = reg_wdata;
          4: m_lo[1] = reg_wdata;
          5: m_hi[1] = reg_wdata;
          default: ;
        endcase
      end
      for (int i = 0; i < 2; i++) begin
        base = (reg_we && reg_waddr == 3'd1) ? reg_wdata[2 + i] : m_flag[i];
        m_flag[i] = (base && !flag_clr[i]) || set[i];
        cp[i] = c2[i]; c2[i] = c1[i]; c1[i] = cnt_pin[i];
        g2[i] = g1[i]; g1[i] = gate_pin[i];
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (chk_on && rst_n) begin
      for (int a = 0; a < 7; a++) begin
        reg_raddr = 3'(a);
        #0.1;
        chk(cur_req, $sformatf("reg %0d", a), reg_rdata, exp_rd(a));
      end
      chk(cur_req, "ovf0", tmr_ovf[0], m_flag[0]);
      chk(cur_req, "ovf1", tmr_ovf[1], m_flag[1]);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1; reg_waddr = 3'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_sim;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values and unused address
    for (int a = 0; a < 7; a++) begin
      reg_raddr = 3'(a); #0.1;
      chk("R1", "reset reg", reg_rdata, 0);
    end
    chk("R1", "reset ovf", tmr_ovf, 0);
    rst_n = 1; chk_on = 1;

    cur_req = "R5"; tick = 1;
    wr(0, 8'h01); wr(2, 8'hF0); wr(3, 8'hFF); wr(1, 8'h01);
    idle(20);
    chk("R7", "flag0 after 16-bit rollover", tmr_ovf[0], 1);

    cur_req = "R7";
    @(negedge clk); flag_clr = 2'b01; @(negedge clk); flag_clr = 0;
    wr(1, 8'h05); idle(2); wr(1, 8'h01); idle(2);

    cur_req = "R4";
    wr(1, 8'h00); wr(0, 8'h00); wr(4, 8'hFC); wr(5, 8'hFF); wr(1, 8'h02);
    idle(12);

    cur_req = "R6";
    wr(1, 8'h00); wr(0, 8'h02); wr(3, 8'h80); wr(2, 8'hFD); wr(1, 8'h01);
    idle(12);

    cur_req = "R8";
    wr(1, 8'h00); idle(3); wr(1, 8'h03); wr(1, 8'h00); idle(3);

    cur_req = "R3";
    tick = 0; wr(0, 8'h05); wr(2, 8'hFE); wr(3, 8'hFF); wr(1, 8'h01);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); cnt_pin[0] = 0; idle(3); cnt_pin[0] = 1; idle(2);
    end

    cur_req = "R2";
    tick = 1; wr(0, 8'h09); gate_pin[0] = 0; idle(10); gate_pin[0] = 1; idle(10);
    gate_pin[0] = 0; idle(4);

    cur_req = "R9";
    wr(0, 8'h31); wr(4, 8'h55); wr(1, 8'h03); idle(12);

    cur_req = "R10";
    wr(1, 8'h00); wr(0, 8'h13); wr(2, 8'hFD); wr(3, 8'hFC); wr(4, 8'hFE); wr(5, 8'hFF);
    wr(1, 8'h03); idle(12); wr(1, 8'h02); idle(6);

    cur_req = "R11";
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      tick = $urandom_range(0, 1);
      cnt_pin = 2'($urandom); gate_pin = 2'($urandom);
      flag_clr = ($urandom_range(0, 15) == 0) ? 2'($urandom) : 2'b00;
      reg_we = ($urandom_range(0, 11) == 0);
      reg_waddr = 3'($urandom_range(0, 6));
      reg_wdata = 8'($urandom);
      if (reg_waddr == 3'd2 || reg_waddr == 3'd4) reg_wdata[7:4] = 4'hF;
    end
    @(negedge clk); reg_we = 0; flag_clr = 0;
    idle(4);
    done = 1;
    finish_sim();
  end
endmodule